// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O

This block gives a processor three byte-wide parallel ports (A, B and C) behind a four-location register window. The processor picks a location with a 2-bit address, qualifies the access with an active-low chip select, and uses active-low read and write strobes. Every port has an output latch that always drives its output pins, an output-enable vector for an external tri-state pad, and an input path that passes the pin level through a synchronizer. Port C is split into two nibbles, and each nibble has its own direction.

The fourth location is a write-only control register that accepts two kinds of command, chosen by bit 7 of the written byte. A configuration command sets all four port directions and the mode fields. It also clears every output latch. A single-bit command sets or clears one port C latch bit and leaves the configuration untouched. Only simple, unhandshaked transfers are supported. Mode fields with other values are stored but act as simple mode.

Top module: `pio3_core`

## Requirements
- R1: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register. A write takes effect in the clock cycle where `wr_n` is first sampled high after being sampled low, using the `cs_n`, `addr` and `wdata` sampled in that cycle. Its result is visible on the outputs after that clock edge.
- R2: A control write with bit 7 = 1 stores a configuration. In that byte, bit 4 = 1 makes port A an input, bit 3 = 1 makes the upper C nibble an input, bit 1 = 1 makes port B an input and bit 0 = 1 makes the lower C nibble an input. Each output-enable bit is 1 exactly when its port or nibble is an output.
- R3: A configuration write clears the port A, B and C output latches to 0x00.
- R4: A control write with bit 7 = 0 is a single-bit command. Bits 3:1 select the port C bit and bit 0 is its new value. No other latch bit changes, and no direction changes.
- R5: While `rst_n` is low, every output latch is 0x00 and every output enable is 0, which means all ports are inputs.
- R6: A read at address 3 returns 0x00 and never returns the control word. `rdata` is 0x00 whenever `cs_n` or `rd_n` is high.
- R7: Reading a port set as output returns its output latch. Reading a port set as input returns the pin level from SYNC_STAGES clock edges earlier.
- R8: The two port C nibbles follow their own directions, both for the output enable and for the nibble returned on a read.
- R9: The configuration byte 0x9B makes all four port sections inputs.
- R10: A non-zero mode field (bits 6:5 for group A, bit 2 for group B) changes nothing but the directions. For example, 0xA4 makes every section an output with plain latched behaviour.
- R11: A write strobe edge with `cs_n` high changes no latch and no direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, sampled synchronously |
| addr | input | 2 | Location select: port A, port B, port C or control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, 0x00 when not reading |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enable, uniform within each nibble |

## Verification
The checker enforces several properties on every cycle. Each output-enable vector stays uniform per port or per nibble. A single-bit command flips at most one port C latch bit and no enable. A configuration write leaves every latch at zero. Latches and enables hold steady through any cycle without a write event or with chip select high. Reads of the control location and idle reads return zero. Only the bench's scenarios, compared against its cycle-by-cycle model, can show the actual bit layouts. These cover which bit the single-bit command selects, which configuration bit drives which direction, the read values of the 0x9B and 0xA4 words, and the synchronizer latency on input reads.

// File: rtl/pio3_pkg.sv
package pio3_pkg;
   localparam int unsigned PORT_W = 8;
   localparam int unsigned ADDR_W = 2;

   localparam logic [ADDR_W-1:0] SEL_A    = 2'd0;
   localparam logic [ADDR_W-1:0] SEL_B    = 2'd1;
   localparam logic [ADDR_W-1:0] SEL_C    = 2'd2;
   localparam logic [ADDR_W-1:0] SEL_CTRL = 2'd3;

   // Field order matches control word bits 6:0
   typedef struct packed {
      logic [1:0] mode_a;
      logic       a_is_in;
      logic       chi_is_in;
      logic       mode_b;
      logic       b_is_in;
      logic       clo_is_in;
   } pio_cfg_t;

   localparam pio_cfg_t CFG_RESET = '{mode_a: 2'b00, a_is_in: 1'b1, chi_is_in: 1'b1,
                                      mode_b: 1'b0, b_is_in: 1'b1, clo_is_in: 1'b1};
endpackage

// File: rtl/pio3_strobe.sv
module pio3_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic wr_n,
   output logic wr_evt
);
   logic wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_q <= 1'b1;
      else        wr_q <= wr_n;
   end

   // rising edge of the low-active strobe, qualified by select
   assign wr_evt = wr_n & ~wr_q & ~cs_n;
endmodule

// File: rtl/pio3_sync.sv
module pio3_sync #(
   parameter int unsigned WIDTH  = 24,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain[0] <= din;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], din};
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/pio3_regs.sv
module pio3_regs
   import pio3_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_evt,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PORT_W-1:0] wdata,
   output pio_cfg_t          cfg,
   output logic [PORT_W-1:0] lat_a,
   output logic [PORT_W-1:0] lat_b,
   output logic [PORT_W-1:0] lat_c
);
   localparam int unsigned SEL_W = $clog2(PORT_W);

   logic              is_cfg_word;
   logic [SEL_W-1:0]  bit_sel;

   assign is_cfg_word = wdata[PORT_W-1];
   assign bit_sel     = wdata[SEL_W:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg   <= CFG_RESET;
         lat_a <= '0;
         lat_b <= '0;
         lat_c <= '0;
      end else if (wr_evt) begin
         unique case (addr)
            SEL_A: lat_a <= wdata;
            SEL_B: lat_b <= wdata;
            SEL_C: lat_c <= wdata;
            default: begin
               if (is_cfg_word) begin
                  cfg   <= pio_cfg_t'(wdata[PORT_W-2:0]);
                  lat_a <= '0;
                  lat_b <= '0;
                  lat_c <= '0;
               end else begin
                  lat_c[bit_sel] <= wdata[0];
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/pio3_readmux.sv
module pio3_readmux
   import pio3_pkg::*;
(
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PORT_W-1:0] dir_in_c,
   input  logic              a_is_in,
   input  logic              b_is_in,
   input  logic [PORT_W-1:0] lat_a,
   input  logic [PORT_W-1:0] lat_b,
   input  logic [PORT_W-1:0] lat_c,
   input  logic [PORT_W-1:0] pin_a,
   input  logic [PORT_W-1:0] pin_b,
   input  logic [PORT_W-1:0] pin_c,
   output logic [PORT_W-1:0] rdata
);
   logic [PORT_W-1:0] c_view;

   // per-bit select lets the two C nibbles differ
   assign c_view = (pin_c & dir_in_c) | (lat_c & ~dir_in_c);

   always_comb begin
      rdata = '0;
      if (!cs_n && !rd_n) begin
         unique case (addr)
            SEL_A:   rdata = a_is_in ? pin_a : lat_a;
            SEL_B:   rdata = b_is_in ? pin_b : lat_b;
            SEL_C:   rdata = c_view;
            default: rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/pio3_core.sv
module pio3_core
   import pio3_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] pa_in,
   output logic [DATA_W-1:0] pa_out,
   output logic [DATA_W-1:0] pa_oe,
   input  logic [DATA_W-1:0] pb_in,
   output logic [DATA_W-1:0] pb_out,
   output logic [DATA_W-1:0] pb_oe,
   input  logic [DATA_W-1:0] pc_in,
   output logic [DATA_W-1:0] pc_out,
   output logic [DATA_W-1:0] pc_oe
);
   localparam int unsigned HALF_W = DATA_W / 2;
   localparam int unsigned PIN_W  = 3 * DATA_W;

   generate
      if (DATA_W != PORT_W) begin : g_bad_width
         $error("pio3_core: DATA_W must equal the package port width");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("pio3_core: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic              wr_evt;
   pio_cfg_t          cfg;
   logic [DATA_W-1:0] lat_a, lat_b, lat_c;
   logic [PIN_W-1:0]  pins_sync;
   logic [DATA_W-1:0] dir_in_c;

   pio3_strobe u_strobe (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n   (cs_n),
      .wr_n   (wr_n),
      .wr_evt (wr_evt)
   );

   pio3_regs u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_evt (wr_evt),
      .addr   (addr),
      .wdata  (wdata),
      .cfg    (cfg),
      .lat_a  (lat_a),
      .lat_b  (lat_b),
      .lat_c  (lat_c)
   );

   pio3_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({pc_in, pb_in, pa_in}),
      .dout  (pins_sync)
   );

   // per-bit input mask for port C, one nibble direction per half
   generate
      for (genvar g = 0; g < DATA_W; g++) begin : g_cdir
         if (g < HALF_W) begin : g_lo
            assign dir_in_c[g] = cfg.clo_is_in;
         end else begin : g_hi
            assign dir_in_c[g] = cfg.chi_is_in;
         end
      end
   endgenerate

   pio3_readmux u_rmux (
      .cs_n     (cs_n),
      .rd_n     (rd_n),
      .addr     (addr),
      .dir_in_c (dir_in_c),
      .a_is_in  (cfg.a_is_in),
      .b_is_in  (cfg.b_is_in),
      .lat_a    (lat_a),
      .lat_b    (lat_b),
      .lat_c    (lat_c),
      .pin_a    (pins_sync[DATA_W-1:0]),
      .pin_b    (pins_sync[2*DATA_W-1:DATA_W]),
      .pin_c    (pins_sync[PIN_W-1:2*DATA_W]),
      .rdata    (rdata)
   );

   assign pa_out = lat_a;
   assign pb_out = lat_b;
   assign pc_out = lat_c;
   assign pa_oe  = {DATA_W{~cfg.a_is_in}};
   assign pb_oe  = {DATA_W{~cfg.b_is_in}};
   assign pc_oe  = ~dir_in_c;
endmodule

// File: rtl/pio3_core_chk.sv
module pio3_core_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              rd_n,
   input logic [1:0]        addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [DATA_W-1:0] pa_out,
   input logic [DATA_W-1:0] pa_oe,
   input logic [DATA_W-1:0] pb_out,
   input logic [DATA_W-1:0] pb_oe,
   input logic [DATA_W-1:0] pc_out,
   input logic [DATA_W-1:0] pc_oe,
   input logic              wr_evt
);
   localparam int unsigned HALF_W = DATA_W / 2;

   a_r2_port_oe_uniform: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(pa_oe) == 0 || $countones(pa_oe) == DATA_W) &&
      ($countones(pb_oe) == 0 || $countones(pb_oe) == DATA_W));

   a_r8_nibble_oe_uniform: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(pc_oe[HALF_W-1:0]) == 0 || $countones(pc_oe[HALF_W-1:0]) == HALF_W) &&
      ($countones(pc_oe[DATA_W-1:HALF_W]) == 0 ||
       $countones(pc_oe[DATA_W-1:HALF_W]) == DATA_W - HALF_W));

   a_r3_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && addr == 2'd3 && wdata[DATA_W-1]) |=>
      (pa_out == '0 && pb_out == '0 && pc_out == '0));

   a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && addr == 2'd3 && !wdata[DATA_W-1]) |=>
      ($countones(pc_out ^ $past(pc_out)) <= 1 && $stable(pa_oe) && $stable(pb_oe) &&
       $stable(pc_oe) && $stable(pa_out) && $stable(pb_out)));

   a_r1_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_evt |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                   $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

   a_r11_deselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

   a_r6_ctrl_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !rd_n && addr == 2'd3) |-> rdata == '0);

   a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || rd_n) |-> rdata == '0);
endmodule

bind pio3_core pio3_core_chk #(.DATA_W(DATA_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cs_n   (cs_n),
   .rd_n   (rd_n),
   .addr   (addr),
   .wdata  (wdata),
   .rdata  (rdata),
   .pa_out (pa_out),
   .pa_oe  (pa_oe),
   .pb_out (pb_out),
   .pb_oe  (pb_oe),
   .pc_out (pc_out),
   .pc_oe  (pc_oe),
   .wr_evt (wr_evt)
);

// File: tb/tb_pio3_core.sv
module tb_pio3_core;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
   logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

   pio3_core #(.DATA_W(8), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
      .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
   );

   always #2 clk = ~clk;

   int    checks = 0;
   int    errors = 0;
   bit    finished = 1'b0;
   string cur_req = "R5";

   // behavioural reference state
   bit         m_a_in, m_b_in, m_chi_in, m_clo_in;
   logic [7:0] m_la, m_lb, m_lc;
   bit         m_prev_wr;
   logic [23:0] pin_q[$];

   task automatic model_reset();
      m_a_in = 1; m_b_in = 1; m_chi_in = 1; m_clo_in = 1;
      m_la = 0; m_lb = 0; m_lc = 0;
      m_prev_wr = 1;
      pin_q.delete();
      for (int i = 0; i < SYNC; i++) pin_q.push_back(24'h0);
   endtask

   task automatic model_edge();
      if (!rst_n) begin
         model_reset();
         return;
      end
      if (wr_n && !m_prev_wr && !cs_n) begin
         case (addr)
            2'd0: m_la = wdata;
            2'd1: m_lb = wdata;
            2'd2: m_lc = wdata;
            default: begin
               if (wdata[7]) begin
                  m_a_in = wdata[4]; m_chi_in = wdata[3];
                  m_b_in = wdata[1]; m_clo_in = wdata[0];
                  m_la = 0; m_lb = 0; m_lc = 0;
               end else begin
                  m_lc[wdata[3:1]] = wdata[0];
               end
            end
         endcase
      end
      m_prev_wr = wr_n;
      pin_q.push_back({pc_in, pb_in, pa_in});
      void'(pin_q.pop_front());
   endtask

   task automatic check8(string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
      end
   endtask

   task automatic compare();
      logic [7:0] e_rd, pa_s, pb_s, pc_s, cmask;
      pa_s = pin_q[0][7:0]; pb_s = pin_q[0][15:8]; pc_s = pin_q[0][23:16];
      cmask = {{4{m_chi_in}}, {4{m_clo_in}}};
      e_rd = 8'h00;
      if (!cs_n && !rd_n) begin
         case (addr)
            2'd0: e_rd = m_a_in ? pa_s : m_la;
            2'd1: e_rd = m_b_in ? pb_s : m_lb;
            2'd2: e_rd = (pc_s & cmask) | (m_lc & ~cmask);
            default: e_rd = 8'h00;
         endcase
      end
      check8("pa_out", pa_out, m_la);
      check8("pb_out", pb_out, m_lb);
      check8("pc_out", pc_out, m_lc);
      check8("pa_oe", pa_oe, m_a_in ? 8'h00 : 8'hFF);
      check8("pb_oe", pb_oe, m_b_in ? 8'h00 : 8'hFF);
      check8("pc_oe", pc_oe, ~cmask);
      check8("rdata", rdata, e_rd);
   endtask

   task automatic cyc();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d, bit sel = 1'b1);
      cs_n = ~sel; addr = a; wdata = d; wr_n = 1'b0;
      cyc();
      wr_n = 1'b1;
      cyc();
      cs_n = 1'b1;
      cyc();
   endtask

   task automatic rd(logic [1:0] a, logic [7:0] exp);
      cs_n = 1'b0; rd_n = 1'b0; addr = a;
      cyc();
      check8("directed read", rdata, exp);
      cs_n = 1'b1; rd_n = 1'b1;
      cyc();
   endtask

   task automatic pins(logic [7:0] a, logic [7:0] b, logic [7:0] c);
      pa_in = a; pb_in = b; pc_in = c;
      repeat (SYNC + 1) cyc();
   endtask

   initial begin
      model_reset();
      // R5: reset state
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      check8("R5 oe after reset", pa_oe | pb_oe | pc_oe, 8'h00);

      // R9: all-input word; R7 input reads
      cur_req = "R9";
      wr(2'd3, 8'h9B);
      pins(8'hA5, 8'h3C, 8'h71);
      cur_req = "R7";
      rd(2'd0, 8'hA5);
      rd(2'd1, 8'h3C);
      rd(2'd2, 8'h71);

      // R2/R8: A out, B in, C upper in, C lower out
      cur_req = "R2";
      wr(2'd3, 8'h8A);
      cur_req = "R8";
      wr(2'd0, 8'h5A);
      wr(2'd2, 8'hC3);
      pins(8'h11, 8'h22, 8'h9E);
      rd(2'd0, 8'h5A);
      rd(2'd2, 8'h93);
      rd(2'd1, 8'h22);

      // R3: new configuration clears latches
      cur_req = "R3";
      wr(2'd3, 8'h80);
      check8("R3 latches", pa_out | pb_out | pc_out, 8'h00);

      // R4: single-bit commands
      cur_req = "R4";
      wr(2'd2, 8'h0F);
      wr(2'd3, 8'h0F);
      check8("R4 set bit7", pc_out, 8'h8F);
      wr(2'd3, 8'h04);
      check8("R4 clear bit2", pc_out, 8'h8B);
      wr(2'd3, 8'h0B);
      check8("R4 set bit5", pc_out, 8'hAB);
      check8("R4 dirs kept", pc_oe, 8'hFF);

      // R10: non-zero mode fields
      cur_req = "R10";
      wr(2'd3, 8'hA4);
      wr(2'd1, 8'h66);
      rd(2'd1, 8'h66);
      check8("R10 all out", pa_oe & pb_oe & pc_oe, 8'hFF);

      // R11: deselected writes
      cur_req = "R11";
      wr(2'd0, 8'hEE, 1'b0);
      check8("R11 A kept", pa_out, 8'h00);
      wr(2'd3, 8'h9B, 1'b0);
      check8("R11 dirs kept", pa_oe, 8'hFF);

      // R6: control location reads as zero
      cur_req = "R6";
      wr(2'd3, 8'h95);
      rd(2'd3, 8'h00);

      // R1: random bus traffic against the model
      cur_req = "R1";
      for (int i = 0; i < 3000; i++) begin
         cs_n  = $urandom_range(0, 3) == 0;
         rd_n  = $urandom_range(0, 1) == 0;
         wr_n  = $urandom_range(0, 1) == 0;
         addr  = 2'($urandom_range(0, 3));
         wdata = 8'($urandom);
         pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
         cyc();
      end
      cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
      cyc();

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule